// File: doc/BRIEF.md
# Event Combiner and Remapper

This block takes a wide vector of single-cycle event pulses from across the chip. It routes each one onto one line of a much narrower set of target lines. Those lines feed interrupt selectors or DMA controllers. Software chooses the target of every source event through a word-addressed register bus. Any number of sources may share one target. A source can never reach more than one target, because its routing is held in a single field that a new write overwrites.

Every source has a sticky status bit. The bit is set either by a hardware pulse or by a software write to a trigger register, and both paths behave the same way. A per-source enable keeps an event away from its target but still lets it set its status bit. A global enable gates every target line. The last `N_BC` targets are broadcast targets. Each one is copied unchanged to every one of `N_CORE` consumers, so that several cores see the same pulse in the same cycle.

Registers, word addressed, 32-bit data. `N_EVT` must be a multiple of 32, and source *i* sits in word *i*/32 at bit *i*%32. The target space holds `N_OUT + N_BC` entries: targets 0..N_OUT-1 drive `evt_out`, and target `N_OUT+b` drives broadcast slot *b*.

| Address | Contents |
|---|---|
| 0x000 | global enable in bit 0 |
| 0x010 + w | per-source enable word w |
| 0x020 + w | status word w (read only) |
| 0x030 + w | trigger word w (write 1 to raise, reads 0) |
| 0x040 + w | clear word w (write 1 to clear, reads 0) |
| 0x100 + i | route of source i: bit 31 valid, bits 7:0 target |

Top module: `evt_combiner`

## Requirements
- R1: After reset all outputs are 0, `rsp_valid` is 0, and the global enable, every per-source enable, every status bit and every route register read back as 0.
- R2: A high `hw_evt[i]` sampled at a clock edge sets status bit i. The bit stays set until a clear is written, whatever the enables and routes are.
- R3: Writing 1s to a clear word clears those status bits, and 0 bits leave theirs unchanged. If a set (hardware or trigger) and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Writing 1s to a trigger word raises those sources exactly as a hardware pulse would, both in status and at the outputs.
- R5: A source whose status bit goes from 0 to 1 at an edge produces a 1 on its target line in the cycle after that edge, for one cycle. This happens only if the source is enabled, its route has bit 31 set, and its target is below `N_OUT+N_BC`.
- R6: A set on a source whose status bit is already 1 produces no output pulse.
- R7: Several sources routed to one target and rising in the same cycle produce a single pulse on that one line.
- R8: A route write replaces the source's previous target. After it, the old target no longer responds to that source. A route with bit 31 clear, or with a target of `N_OUT+N_BC` or more, drives nothing.
- R9: A source with its enable bit at 0 drives no target, but its status bit is still set.
- R10: While global enable bit 0 is 0, every output stays 0.
- R11: Broadcast target `N_OUT+b` drives `bcast_out[c*N_BC+b]` for every core c in the same cycle.
- R12: `req_ready` is always 1. A read accepted at an edge returns, in the following cycle, `rsp_valid`=1 and `rsp_data` holding the register's value from before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock for both the event logic and the register bus |
| rst | input | 1 | synchronous active-high reset |
| hw_evt | input | N_EVT | hardware event pulses |
| req_valid | input | 1 | bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | word address |
| req_wdata | input | 32 | write data |
| req_ready | output | 1 | bus request accepted (always 1) |
| rsp_valid | output | 1 | read data valid |
| rsp_data | output | 32 | read data |
| evt_out | output | N_OUT | per-target event lines |
| bcast_out | output | N_CORE*N_BC | broadcast lines, one group of N_BC per core |

## Verification
The bench goes after the cases where a careless design would misfire. A repeated pulse on an already-latched source must stay silent; a design that pulses on every set would emit a second output. A set and a clear in the same cycle must leave the bit set; a design that lets the clear win would silently drop the event. A remap must leave the old target dead; a decoder that keeps a stale target would drive two lines at once. Masked, unrouted, out-of-range and globally disabled sources must latch status yet drive nothing, and a design that shares the mask between status and output would lose the status. A random phase then mixes pulses, triggers, clears, remaps and reads against a cycle-accurate model.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] A_GCTL = 12'h000;
    localparam logic [AW-1:0] A_EN   = 12'h010;
    localparam logic [AW-1:0] A_ST   = 12'h020;
    localparam logic [AW-1:0] A_TRIG = 12'h030;
    localparam logic [AW-1:0] A_CLR  = 12'h040;
    localparam logic [AW-1:0] A_MAP  = 12'h100;

    localparam int MAP_VLD_BIT = 31;
    localparam int TGT_BITS    = 8;

    typedef struct packed {
        logic                vld;
        logic [TGT_BITS-1:0] tgt;
    } route_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GCTL,
        SEL_EN,
        SEL_ST,
        SEL_TRIG,
        SEL_CLR,
        SEL_MAP
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic [AW-1:0] off;
    } reg_dec_t;

    function automatic logic in_window(logic [AW-1:0] a, logic [AW-1:0] base, int n);
        return (a >= base) && (int'(a - base) < n);
    endfunction

    function automatic reg_dec_t decode(logic [AW-1:0] a, int nwords, int nevt);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.off = '0;
        if (a == A_GCTL) begin
            d.sel = SEL_GCTL;
        end else if (in_window(a, A_EN, nwords)) begin
            d.sel = SEL_EN;
            d.off = a - A_EN;
        end else if (in_window(a, A_ST, nwords)) begin
            d.sel = SEL_ST;
            d.off = a - A_ST;
        end else if (in_window(a, A_TRIG, nwords)) begin
            d.sel = SEL_TRIG;
            d.off = a - A_TRIG;
        end else if (in_window(a, A_CLR, nwords)) begin
            d.sel = SEL_CLR;
            d.off = a - A_CLR;
        end else if (in_window(a, A_MAP, nevt)) begin
            d.sel = SEL_MAP;
            d.off = a - A_MAP;
        end
        return d;
    endfunction

    function automatic logic [DW-1:0] pack_route(route_t r);
        logic [DW-1:0] w;
        w = '0;
        w[MAP_VLD_BIT] = r.vld;
        w[TGT_BITS-1:0] = r.tgt;
        return w;
    endfunction

endpackage

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int N_EVT = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [N_EVT-1:0] status_q,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             gen_en,
    output logic [N_EVT-1:0] en_q,
    output route_t           route_q [N_EVT],
    output logic [N_EVT-1:0] sw_set,
    output logic [N_EVT-1:0] sw_clr
);
    localparam int NW = N_EVT / DW;

    reg_dec_t      dec;
    int            idx;
    logic          wr_acc;
    logic          rd_acc;
    logic [DW-1:0] rdata_c;

    assign req_ready = 1'b1;
    assign wr_acc    = req_valid & req_write;
    assign rd_acc    = req_valid & ~req_write;

    always_comb begin
        dec = decode(req_addr, NW, N_EVT);
        idx = int'(dec.off);
    end

    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (wr_acc && dec.sel == SEL_TRIG) sw_set[idx*DW +: DW] = req_wdata;
        if (wr_acc && dec.sel == SEL_CLR)  sw_clr[idx*DW +: DW] = req_wdata;
    end

    always_comb begin
        rdata_c = '0;
        case (dec.sel)
            SEL_GCTL: rdata_c[0] = gen_en;
            SEL_EN:   rdata_c = en_q[idx*DW +: DW];
            SEL_ST:   rdata_c = status_q[idx*DW +: DW];
            SEL_MAP:  rdata_c = pack_route(route_q[idx]);
            default:  rdata_c = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en <= 1'b0;
            en_q   <= '0;
            for (int i = 0; i < N_EVT; i++) route_q[i] <= '0;
        end else if (wr_acc) begin
            case (dec.sel)
                SEL_GCTL: gen_en <= req_wdata[0];
                SEL_EN:   en_q[idx*DW +: DW] <= req_wdata;
                SEL_MAP: begin
                    route_q[idx].vld <= req_wdata[MAP_VLD_BIT];
                    route_q[idx].tgt <= req_wdata[TGT_BITS-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_acc;
            rsp_data  <= rd_acc ? rdata_c : '0;
        end
    end

endmodule

// File: rtl/evc_stat.sv
module evc_stat #(
    parameter int N_EVT = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] hw_evt,
    input  logic [N_EVT-1:0] sw_set,
    input  logic [N_EVT-1:0] sw_clr,
    output logic [N_EVT-1:0] status_q,
    output logic [N_EVT-1:0] rise
);
    logic [N_EVT-1:0] set_c;

    assign set_c = hw_evt | sw_set;
    assign rise  = set_c & ~status_q;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~sw_clr) | set_c;
    end

endmodule

// File: rtl/evc_route.sv
module evc_route
    import evc_pkg::*;
#(
    parameter int N_EVT = 128,
    parameter int N_TGT = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] rise,
    input  logic [N_EVT-1:0] en_q,
    input  logic             gen_en,
    input  route_t           route_q [N_EVT],
    output logic [N_TGT-1:0] tgt_q
);
    logic [N_TGT-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N_EVT; i++) begin
            if (rise[i] && en_q[i] && route_q[i].vld && int'(route_q[i].tgt) < N_TGT)
                acc[route_q[i].tgt] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         tgt_q <= '0;
        else if (gen_en) tgt_q <= acc;
        else             tgt_q <= '0;
    end

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
    import evc_pkg::*;
#(
    parameter int N_EVT  = 128,
    parameter int N_OUT  = 32,
    parameter int N_BC   = 8,
    parameter int N_CORE = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_EVT-1:0]       hw_evt,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [11:0]            req_addr,
    input  logic [31:0]            req_wdata,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_data,
    output logic [N_OUT-1:0]       evt_out,
    output logic [N_CORE*N_BC-1:0] bcast_out
);
    localparam int N_TGT = N_OUT + N_BC;

    logic             gen_en;
    logic [N_EVT-1:0] en_q;
    route_t           route_q [N_EVT];
    logic [N_EVT-1:0] sw_set;
    logic [N_EVT-1:0] sw_clr;
    logic [N_EVT-1:0] status_q;
    logic [N_EVT-1:0] rise;
    logic [N_TGT-1:0] tgt_q;

    evc_regs #(.N_EVT(N_EVT)) u_regs (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .status_q(status_q),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .gen_en(gen_en), .en_q(en_q), .route_q(route_q),
        .sw_set(sw_set), .sw_clr(sw_clr)
    );

    evc_stat #(.N_EVT(N_EVT)) u_stat (
        .clk(clk), .rst(rst),
        .hw_evt(hw_evt), .sw_set(sw_set), .sw_clr(sw_clr),
        .status_q(status_q), .rise(rise)
    );

    evc_route #(.N_EVT(N_EVT), .N_TGT(N_TGT)) u_route (
        .clk(clk), .rst(rst),
        .rise(rise), .en_q(en_q), .gen_en(gen_en), .route_q(route_q),
        .tgt_q(tgt_q)
    );

    assign evt_out = tgt_q[N_OUT-1:0];

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        assign bcast_out[c*N_BC +: N_BC] = tgt_q[N_OUT +: N_BC];
    end

endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
    parameter int N_EVT  = 128,
    parameter int N_OUT  = 32,
    parameter int N_BC   = 8,
    parameter int N_CORE = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_EVT-1:0]       hw_evt,
    input logic [N_EVT-1:0]       sw_clr,
    input logic [N_EVT-1:0]       status_q,
    input logic                   gen_en,
    input logic                   req_valid,
    input logic                   req_write,
    input logic                   rsp_valid,
    input logic [N_OUT-1:0]       evt_out,
    input logic [N_CORE*N_BC-1:0] bcast_out
);
    logic any_out;
    assign any_out = |{evt_out, bcast_out};

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((~status_q) & $past(status_q) & ~$past(sw_clr)) == '0);

    // R3
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hw_evt & sw_clr) & ~status_q) == '0);

    // R10
    gated_output_chk: assert property (@(posedge clk) disable iff (rst)
        any_out |-> $past(gen_en));

    // R5
    pulse_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        any_out |-> (|(status_q & ~$past(status_q))));

    // R12
    read_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind evt_combiner evc_chk #(
    .N_EVT(N_EVT), .N_OUT(N_OUT), .N_BC(N_BC), .N_CORE(N_CORE)
) u_chk (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .sw_clr(sw_clr),
    .status_q(status_q), .gen_en(gen_en),
    .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid),
    .evt_out(evt_out), .bcast_out(bcast_out)
);

// File: tb/tb_evt_combiner.sv
module tb_evt_combiner;
    localparam int NE = 128;
    localparam int NO = 32;
    localparam int NB = 8;
    localparam int NC = 8;
    localparam int NT = NO + NB;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NE-1:0]   hw_evt = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            req_ready;
    logic            rsp_valid;
    logic [31:0]     rsp_data;
    logic [NO-1:0]   evt_out;
    logic [NC*NB-1:0] bcast_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    evt_combiner dut (
        .clk(clk), .rst(rst), .hw_evt(hw_evt),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .evt_out(evt_out), .bcast_out(bcast_out)
    );

    always #10 clk = ~clk;

    // reference model state
    bit            m_gen;
    bit [NE-1:0]   m_en;
    bit [NE-1:0]   m_st;
    bit            m_vld [NE];
    int            m_tgt [NE];
    bit [NT-1:0]   exp_tgt;
    bit            exp_rv;
    bit [31:0]     exp_rd;

    function automatic bit [31:0] model_read(bit [11:0] a);
        if (a == 12'h000) return {31'b0, m_gen};
        if (a >= 12'h010 && a < 12'h014) return m_en[(a - 12'h010) * 32 +: 32];
        if (a >= 12'h020 && a < 12'h024) return m_st[(a - 12'h020) * 32 +: 32];
        if (a >= 12'h100 && a < 12'h180)
            return {m_vld[a - 12'h100], 23'b0, 8'(m_tgt[a - 12'h100])};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_gen = 0; m_en = '0; m_st = '0; exp_tgt = '0; exp_rv = 0; exp_rd = '0;
            for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_tgt[i] = 0; end
        end else begin
            bit [NE-1:0] s, c, f;
            bit [NT-1:0] nt;
            s = hw_evt; c = '0; nt = '0;
            exp_rv = req_valid && !req_write;
            exp_rd = exp_rv ? model_read(req_addr) : 32'h0;
            if (req_valid && req_write) begin
                if (req_addr >= 12'h030 && req_addr < 12'h034) s[(req_addr - 12'h030) * 32 +: 32] |= req_wdata;
                if (req_addr >= 12'h040 && req_addr < 12'h044) c[(req_addr - 12'h040) * 32 +: 32] = req_wdata;
            end
            f = s & ~m_st;
            for (int i = 0; i < NE; i++)
                if (f[i] && m_en[i] && m_vld[i] && m_tgt[i] < NT && m_gen) nt[m_tgt[i]] = 1;
            exp_tgt = nt;
            m_st = (m_st & ~c) | s;
            if (req_valid && req_write) begin
                if (req_addr == 12'h000) m_gen = req_wdata[0];
                if (req_addr >= 12'h010 && req_addr < 12'h014) m_en[(req_addr - 12'h010) * 32 +: 32] = req_wdata;
                if (req_addr >= 12'h100 && req_addr < 12'h180) begin
                    m_vld[req_addr - 12'h100] = req_wdata[31];
                    m_tgt[req_addr - 12'h100] = int'(req_wdata[7:0]);
                end
            end
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check({cur_req, " evt_out"}, 64'(evt_out), 64'(exp_tgt[NO-1:0]));
            for (int c = 0; c < NC; c++)
                check("R11 bcast copy", 64'(bcast_out[c*NB +: NB]), 64'(exp_tgt[NT-1:NO]));
            check("R12 rsp_valid", 64'(rsp_valid), 64'(exp_rv));
            if (exp_rv) check("R12 rsp_data", 64'(rsp_data), 64'(exp_rd));
            check("R12 ready", 64'(req_ready), 64'd1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R12 watchdog expired actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] e, string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check(tag, 64'(rsp_data), 64'(e));
    endtask

    task automatic pulse(int i);
        hw_evt[i] = 1'b1;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic clear_all();
        for (int w = 0; w < 4; w++) bus_wr(12'h040 + 12'(w), 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 evt_out", 64'(evt_out), 64'd0);
        check("R1 bcast", 64'(bcast_out), 64'd0);
        rd_chk(12'h000, 32'h0, "R1 gctl");
        rd_chk(12'h011, 32'h0, "R1 enable");
        rd_chk(12'h023, 32'h0, "R1 status");
        rd_chk(12'h17F, 32'h0, "R1 route");

        bus_wr(12'h000, 32'h1);
        for (int w = 0; w < 4; w++) bus_wr(12'h010 + 12'(w), 32'hFFFF_FFFF);
        bus_wr(12'h100 + 12'd5,   32'h8000_0003);
        bus_wr(12'h100 + 12'd70,  32'h8000_0003);
        bus_wr(12'h100 + 12'd9,   32'h8000_0022);
        bus_wr(12'h100 + 12'd100, 32'h0000_000A);
        bus_wr(12'h100 + 12'd127, 32'h8000_00C8);
        rd_chk(12'h105, 32'h8000_0003, "R12 route readback");
        rd_chk(12'h050, 32'h0, "R12 unmapped read");

        cur_req = "R5";
        pulse(5);
        check("R5 pulse on target 3", 64'(evt_out), 64'h8);
        @(negedge clk);
        check("R5 one cycle only", 64'(evt_out), 64'h0);
        rd_chk(12'h020, 32'h20, "R2 status latched");

        cur_req = "R6";
        pulse(5);
        check("R6 no repeat pulse", 64'(evt_out), 64'h0);

        cur_req = "R3";
        bus_wr(12'h040, 32'h0000_0001);
        rd_chk(12'h020, 32'h20, "R3 zero bits keep status");
        bus_wr(12'h040, 32'h20);
        rd_chk(12'h020, 32'h0, "R3 clear");

        cur_req = "R7";
        hw_evt[5] = 1; hw_evt[70] = 1;
        @(negedge clk);
        hw_evt = '0;
        check("R7 combined single line", 64'(evt_out), 64'h8);
        clear_all();

        cur_req = "R11";
        pulse(9);
        check("R11 bcast slot 2", 64'(bcast_out), 64'h0404_0404_0404_0404);
        clear_all();

        cur_req = "R8";
        bus_wr(12'h100 + 12'd5, 32'h8000_0007);
        pulse(5);
        check("R8 remapped target", 64'(evt_out), 64'h80);
        pulse(100);
        check("R8 invalid route", 64'(evt_out), 64'h0);
        pulse(127);
        check("R8 out of range target", 64'({bcast_out, evt_out}), 64'h0);
        rd_chk(12'h023, 32'h8000_0010, "R8 status still set");
        clear_all();

        cur_req = "R4";
        bus_wr(12'h032, 32'h40);
        check("R4 trigger drives output", 64'(evt_out), 64'h8);
        rd_chk(12'h022, 32'h40, "R4 trigger sets status");

        cur_req = "R3";
        hw_evt[70] = 1; req_valid = 1; req_write = 1; req_addr = 12'h042; req_wdata = 32'h40;
        @(negedge clk);
        hw_evt = '0; req_valid = 0; req_write = 0;
        rd_chk(12'h022, 32'h40, "R3 set wins over clear");
        clear_all();

        cur_req = "R9";
        bus_wr(12'h010, 32'hFFFF_FFDF);
        pulse(5);
        check("R9 masked no output", 64'(evt_out), 64'h0);
        rd_chk(12'h020, 32'h20, "R9 masked still latched");
        bus_wr(12'h010, 32'hFFFF_FFFF);
        clear_all();

        cur_req = "R10";
        bus_wr(12'h000, 32'h0);
        pulse(70);
        check("R10 global off", 64'(evt_out), 64'h0);
        rd_chk(12'h000, 32'h0, "R10 gctl readback");
        bus_wr(12'h000, 32'h1);
        clear_all();

        cur_req = "R8 random";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            hw_evt = '0;
            for (int k = 0; k < 3; k++) hw_evt[$urandom_range(0, NE-1)] = ($urandom_range(0, 3) == 0);
            req_valid = 0; req_write = 0;
            if (r == 0) begin
                req_valid = 1; req_write = 1; req_addr = 12'h040 + 12'($urandom_range(0, 3)); req_wdata = $urandom;
            end else if (r == 1) begin
                req_valid = 1; req_write = 1; req_addr = 12'h030 + 12'($urandom_range(0, 3)); req_wdata = $urandom & $urandom;
            end else if (r == 2) begin
                req_valid = 1; req_write = 1; req_addr = 12'h100 + 12'($urandom_range(0, NE-1));
                req_wdata = {1'($urandom_range(0, 7) != 0), 23'b0, 8'($urandom_range(0, 47))};
            end else if (r == 3) begin
                req_valid = 1; req_write = 0; req_addr = 12'($urandom_range(0, 12'h180));
            end else if (r == 4 && $urandom_range(0, 20) == 0) begin
                req_valid = 1; req_write = 1; req_addr = 12'h000; req_wdata = 32'($urandom_range(0, 3) != 0);
            end
            @(negedge clk);
        end
        hw_evt = '0; req_valid = 0; req_write = 0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule